// File: doc/BRIEF.md
# Bus Master Direction Arbiter

This block picks which of two DMA directions may use a shared bus-mastering engine. The read channel moves data from the bus into an inbound FIFO. The write channel moves data from an outbound FIFO onto the bus. Each channel raises a request when its own FIFO level calls for a transfer. The arbiter then hands the engine to one channel at a time. The threshold logic that produces the requests and the bus protocol that runs each transfer both sit outside this block.

Two bits of a control word set the priority policy. Bit 12 is the read-first bit and bit 8 is the write-first bit. With exactly one of them set, that direction always wins a tie. With both set or both clear, ties alternate between the two directions. A decision is taken only while the engine is idle. Once a grant is issued it stays with its owner until the owner lets its busy line fall, so a grant is never taken away.

The controller is a three-state machine with the states IDLE, OWN_RD and OWN_WR:
- IDLE to OWN_RD when the read channel wins a decision.
- IDLE to OWN_WR when the write channel wins a decision.
- OWN_RD to IDLE when the read busy line is low.
- OWN_WR to IDLE when the write busy line is low.
- Every other case holds the current state.

A second two-state machine, TURN_RD and TURN_WR, records which direction wins the next tie in alternating mode. It moves from one state to the other only when a contested decision is taken in that mode.

Top module: `bm_dir_arbiter`

## Requirements
- R1: After reset both grant outputs are low, the controller is in IDLE, and the tie pointer is in TURN_RD.
- R2: When control bits 12 and 8 are equal (both 0 or both 1), a decision with both requests high goes to the direction named by the tie pointer. The first such decision after reset goes to read, and later ones alternate read, write, read.
- R3: When bit 12 is 1 and bit 8 is 0, a decision with both requests high grants read.
- R4: When bit 8 is 1 and bit 12 is 0, a decision with both requests high grants write.
- R5: While a channel owns the engine and holds its busy line high, its grant stays high. A request from the other direction is ignored.
- R6: In IDLE, a single active request is granted under every policy.
- R7: The tie pointer changes only on a contested decision made in alternating mode. Uncontested decisions and decisions in either fixed mode leave it unchanged.
- R8: The grants are registered and one-hot: gnt_rd is bit 0 of the grant pair and gnt_wr is bit 1. A grant rises one clock after its request is sampled in IDLE. It falls one clock after the owner's busy line is sampled low, and at least one IDLE cycle follows before the next grant.
- R9: A change of control bits during an ownership has no effect on that grant. The new policy applies from the next decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | 16 | Control word; bit 12 read-first, bit 8 write-first |
| rd_req | input | 1 | Read channel request |
| wr_req | input | 1 | Write channel request |
| rd_busy | input | 1 | Read channel still holds the engine |
| wr_busy | input | 1 | Write channel still holds the engine |
| gnt_rd | output | 1 | Engine granted to read channel |
| gnt_wr | output | 1 | Engine granted to write channel |

## Verification
The hardest state to reach is a tie pointer whose value does not simply follow the last grant. Getting there requires uncontested grants and fixed-mode ties mixed between the alternating ties, so that a port-level observer cannot predict the next tie from recent grants alone. The stimulus does this on purpose. It inserts lone-request grants and a run of fixed-priority ties between alternating ties, then switches back to alternating mode and checks that the pointer resumed where it had stopped. It also changes the policy bits in the middle of an ownership and keeps the opposing request high during every ownership, which exercises both the no-preemption rule and the deferred policy change.

// File: rtl/bmarb_pkg.sv
package bmarb_pkg;

    typedef enum logic [1:0] {
        POL_ALT      = 2'd0,
        POL_RD_FIRST = 2'd1,
        POL_WR_FIRST = 2'd2
    } policy_e;

    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_RD   = 2'd1,
        PICK_WR   = 2'd2
    } pick_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OWN_RD = 2'd1,
        ST_OWN_WR = 2'd2
    } own_state_e;

    typedef enum logic {
        TURN_RD = 1'b0,
        TURN_WR = 1'b1
    } turn_e;

    localparam int unsigned NUM_CHAN = 2;
    localparam int unsigned CH_RD    = 0;
    localparam int unsigned CH_WR    = 1;

endpackage

// File: rtl/bmarb_policy_decode.sv
module bmarb_policy_decode
    import bmarb_pkg::*;
#(
    parameter int unsigned CTRL_W     = 16,
    parameter int unsigned RD_PRI_BIT = 12,
    parameter int unsigned WR_PRI_BIT = 8
) (
    input  logic [CTRL_W-1:0] ctrl_word,
    output policy_e           policy
);

    logic [1:0] sel;

    assign sel = {ctrl_word[RD_PRI_BIT], ctrl_word[WR_PRI_BIT]};

    always_comb begin
        unique case (sel)
            2'b10:   policy = POL_RD_FIRST;
            2'b01:   policy = POL_WR_FIRST;
            default: policy = POL_ALT;
        endcase
    end

endmodule

// File: rtl/bmarb_turn_tracker.sv
module bmarb_turn_tracker
    import bmarb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    output logic turn_rd
);

    turn_e turn_q;
    turn_e turn_d;

    always_comb begin
        turn_d = turn_q;
        unique case (turn_q)
            TURN_RD: if (advance) turn_d = TURN_WR;
            TURN_WR: if (advance) turn_d = TURN_RD;
            default: turn_d = TURN_RD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            turn_q <= TURN_RD;
        end else begin
            turn_q <= turn_d;
        end
    end

    assign turn_rd = (turn_q == TURN_RD);

endmodule

// File: rtl/bmarb_pick.sv
module bmarb_pick
    import bmarb_pkg::*;
(
    input  policy_e policy,
    input  logic    rd_req,
    input  logic    wr_req,
    input  logic    turn_rd,
    output pick_e   pick,
    output logic    contested
);

    logic [NUM_CHAN-1:0] req_vec;

    assign req_vec[CH_RD] = rd_req;
    assign req_vec[CH_WR] = wr_req;
    assign contested      = &req_vec;

    always_comb begin
        pick = PICK_NONE;
        unique case (req_vec)
            2'b01: pick = PICK_RD;
            2'b10: pick = PICK_WR;
            2'b11: begin
                unique case (policy)
                    POL_RD_FIRST: pick = PICK_RD;
                    POL_WR_FIRST: pick = PICK_WR;
                    default:      pick = turn_rd ? PICK_RD : PICK_WR;
                endcase
            end
            default: pick = PICK_NONE;
        endcase
    end

endmodule

// File: rtl/bmarb_grant_fsm.sv
module bmarb_grant_fsm
    import bmarb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  pick_e pick,
    input  logic  rd_busy,
    input  logic  wr_busy,
    output logic  decide,
    output logic  gnt_rd,
    output logic  gnt_wr
);

    own_state_e          state_q;
    own_state_e          state_d;
    logic [NUM_CHAN-1:0] busy_vec;
    logic [NUM_CHAN-1:0] release_vec;

    assign busy_vec[CH_RD] = rd_busy;
    assign busy_vec[CH_WR] = wr_busy;

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_release
        assign release_vec[c] = ~busy_vec[c];
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                unique case (pick)
                    PICK_RD: state_d = ST_OWN_RD;
                    PICK_WR: state_d = ST_OWN_WR;
                    default: state_d = ST_IDLE;
                endcase
            end
            ST_OWN_RD: if (release_vec[CH_RD]) state_d = ST_IDLE;
            ST_OWN_WR: if (release_vec[CH_WR]) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_rd <= 1'b0;
            gnt_wr <= 1'b0;
        end else begin
            gnt_rd <= (state_d == ST_OWN_RD);
            gnt_wr <= (state_d == ST_OWN_WR);
        end
    end

    assign decide = (state_q == ST_IDLE) && (pick != PICK_NONE);

endmodule

// File: rtl/bm_dir_arbiter.sv
module bm_dir_arbiter
    import bmarb_pkg::*;
#(
    parameter int unsigned CTRL_W     = 16,
    parameter int unsigned RD_PRI_BIT = 12,
    parameter int unsigned WR_PRI_BIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic              rd_busy,
    input  logic              wr_busy,
    output logic              gnt_rd,
    output logic              gnt_wr
);

    localparam int unsigned TOP_BIT = CTRL_W - 1;

    policy_e policy;
    pick_e   pick;
    logic    contested;
    logic    decide;
    logic    turn_rd;
    logic    advance;

    bmarb_policy_decode #(
        .CTRL_W     (CTRL_W),
        .RD_PRI_BIT (RD_PRI_BIT),
        .WR_PRI_BIT (WR_PRI_BIT)
    ) u_policy (
        .ctrl_word (ctrl_word),
        .policy    (policy)
    );

    bmarb_pick u_pick (
        .policy    (policy),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .turn_rd   (turn_rd),
        .pick      (pick),
        .contested (contested)
    );

    bmarb_grant_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pick    (pick),
        .rd_busy (rd_busy),
        .wr_busy (wr_busy),
        .decide  (decide),
        .gnt_rd  (gnt_rd),
        .gnt_wr  (gnt_wr)
    );

    // The tie pointer moves only on a contested decision in alternating mode.
    assign advance = decide && contested && (policy == POL_ALT);

    bmarb_turn_tracker u_turn (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .turn_rd (turn_rd)
    );

    initial begin
        if (RD_PRI_BIT > TOP_BIT || WR_PRI_BIT > TOP_BIT || RD_PRI_BIT == WR_PRI_BIT) begin
            $error("bm_dir_arbiter: bad priority bit positions");
        end
    end

endmodule

// File: rtl/bmarb_checker.sv
module bmarb_checker #(
    parameter int unsigned CTRL_W     = 16,
    parameter int unsigned RD_PRI_BIT = 12,
    parameter int unsigned WR_PRI_BIT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CTRL_W-1:0] ctrl_word,
    input logic              rd_req,
    input logic              wr_req,
    input logic              rd_busy,
    input logic              wr_busy,
    input logic              gnt_rd,
    input logic              gnt_wr,
    input logic              turn_rd
);

    logic idle;
    logic both;
    logic alt_mode;

    assign idle     = !gnt_rd && !gnt_wr;
    assign both     = rd_req && wr_req;
    assign alt_mode = (ctrl_word[RD_PRI_BIT] == ctrl_word[WR_PRI_BIT]);

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({gnt_wr, gnt_rd})); // R8
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) gnt_rd && rd_busy |=> gnt_rd); // R5
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) gnt_wr && wr_busy |=> gnt_wr); // R5
    AST_RD_DROP: assert property (@(posedge clk) disable iff (!rst_n) gnt_rd && !rd_busy |=> idle); // R8
    AST_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n) gnt_wr && !wr_busy |=> idle); // R8
    AST_FIX_RD: assert property (@(posedge clk) disable iff (!rst_n)
        idle && both && ctrl_word[RD_PRI_BIT] && !ctrl_word[WR_PRI_BIT] |=> gnt_rd); // R3
    AST_FIX_WR: assert property (@(posedge clk) disable iff (!rst_n)
        idle && both && ctrl_word[WR_PRI_BIT] && !ctrl_word[RD_PRI_BIT] |=> gnt_wr); // R4
    AST_ALT_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        idle && both && alt_mode |=> (gnt_rd == $past(turn_rd))); // R2
    AST_LONE_RD: assert property (@(posedge clk) disable iff (!rst_n) idle && rd_req && !wr_req |=> gnt_rd); // R6
    AST_LONE_WR: assert property (@(posedge clk) disable iff (!rst_n) idle && wr_req && !rd_req |=> gnt_wr); // R6
    AST_TURN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !(idle && both && alt_mode) |=> $stable(turn_rd)); // R7
    AST_IDLE_STAY: assert property (@(posedge clk) disable iff (!rst_n) idle && !rd_req && !wr_req |=> idle); // R8

endmodule

bind bm_dir_arbiter bmarb_checker #(
    .CTRL_W     (CTRL_W),
    .RD_PRI_BIT (RD_PRI_BIT),
    .WR_PRI_BIT (WR_PRI_BIT)
) u_bmarb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_word (ctrl_word),
    .rd_req    (rd_req),
    .wr_req    (wr_req),
    .rd_busy   (rd_busy),
    .wr_busy   (wr_busy),
    .gnt_rd    (gnt_rd),
    .gnt_wr    (gnt_wr),
    .turn_rd   (turn_rd)
);

// File: tb/test_bm_dir_arbiter.sv
`timescale 1ns/1ps
module test_bm_dir_arbiter;

    localparam logic [15:0] C_ALT0 = 16'h0000;
    localparam logic [15:0] C_ALT1 = 16'h1100;
    localparam logic [15:0] C_RDF  = 16'h1000;
    localparam logic [15:0] C_WRF  = 16'h0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ctrl_word = C_ALT0;
    logic        rd_req = 1'b0;
    logic        wr_req = 1'b0;
    logic        rd_busy = 1'b0;
    logic        wr_busy = 1'b0;
    logic        gnt_rd;
    logic        gnt_wr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state: 0 none, 1 read owns, 2 write owns.
    int m_owner = 0;
    int m_turn_rd = 1;

    always #4 clk = ~clk;

    bm_dir_arbiter i_bm_dir_arbiter (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_word (ctrl_word),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .rd_busy   (rd_busy),
        .wr_busy   (wr_busy),
        .gnt_rd    (gnt_rd),
        .gnt_wr    (gnt_wr)
    );

    function automatic int grant_code();
        return {30'd0, gnt_wr, gnt_rd};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Behavioural reference model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_owner = 0;
            m_turn_rd = 1;
        end else if (m_owner == 0) begin
            if (rd_req && wr_req) begin
                if (ctrl_word[12] && !ctrl_word[8]) m_owner = 1;
                else if (ctrl_word[8] && !ctrl_word[12]) m_owner = 2;
                else begin
                    m_owner = m_turn_rd ? 1 : 2;
                    m_turn_rd = 1 - m_turn_rd;
                end
            end else if (rd_req) m_owner = 1;
            else if (wr_req) m_owner = 2;
        end else if (m_owner == 1 && !rd_busy) m_owner = 0;
        else if (m_owner == 2 && !wr_busy) m_owner = 0;
    end

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(grant_code() == m_owner, "R8/R5 model compare", grant_code(), m_owner);
        end
    end

    // One ownership: raise requests, check winner, hold with loser pending, release.
    task automatic arb(input bit r, input bit w, input int exp, input string tag,
                       input bit mid_en, input logic [15:0] mid_ctrl);
        rd_req = r;
        wr_req = w;
        @(negedge clk);
        chk(grant_code() == exp, tag, grant_code(), exp);
        if (exp == 1) begin rd_busy = 1'b1; rd_req = 1'b0; end
        if (exp == 2) begin wr_busy = 1'b1; wr_req = 1'b0; end
        for (int i = 0; i < 3; i++) begin
            if (mid_en && i == 0) ctrl_word = mid_ctrl;
            @(negedge clk);
            chk(grant_code() == exp, "R5 hold against other request", grant_code(), exp);
        end
        rd_busy = 1'b0;
        wr_busy = 1'b0;
        rd_req = 1'b0;
        wr_req = 1'b0;
        @(negedge clk);
        chk(grant_code() == 0, "R8 drop one clock after busy low", grant_code(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(grant_code() == 0, "R1 grants low in reset", grant_code(), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(grant_code() == 0, "R1 idle after reset", grant_code(), 0);

        // Alternation with both bits clear, starting with read.
        arb(1, 1, 1, "R2 first tie to read", 0, C_ALT0);
        arb(1, 1, 2, "R2 second tie to write", 0, C_ALT0);
        arb(1, 1, 1, "R2 third tie to read", 0, C_ALT0);
        // Uncontested grant does not move the pointer (pointer at write).
        arb(1, 0, 1, "R6 lone read in alternating mode", 0, C_ALT0);
        arb(1, 1, 2, "R7 pointer kept across lone grant", 0, C_ALT0);
        // Both bits set: still alternating (pointer at read).
        ctrl_word = C_ALT1;
        arb(1, 1, 1, "R2 both bits set alternates", 0, C_ALT0);
        // Fixed read priority (pointer at write, must stay).
        ctrl_word = C_RDF;
        arb(1, 1, 1, "R3 read-first tie", 0, C_ALT0);
        arb(1, 1, 1, "R3 read-first tie again", 0, C_ALT0);
        arb(0, 1, 2, "R6 lone write under read-first", 0, C_ALT0);
        // Fixed write priority.
        ctrl_word = C_WRF;
        arb(1, 1, 2, "R4 write-first tie", 0, C_ALT0);
        arb(1, 1, 2, "R4 write-first tie again", 0, C_ALT0);
        arb(1, 0, 1, "R6 lone read under write-first", 0, C_ALT0);
        // Policy change during ownership is deferred.
        ctrl_word = C_RDF;
        arb(1, 1, 1, "R9 read-first before change", 1, C_WRF);
        arb(1, 1, 2, "R9 new policy at next decision", 0, C_ALT0);
        // Back to alternating: pointer resumes at write.
        ctrl_word = C_ALT0;
        arb(1, 1, 2, "R7 pointer kept through fixed modes", 0, C_ALT0);

        // Pending write waits for release plus one idle cycle.
        rd_req = 1'b1;
        @(negedge clk);
        chk(grant_code() == 1, "R6 lone read granted", grant_code(), 1);
        rd_busy = 1'b1;
        rd_req = 1'b0;
        wr_req = 1'b1;
        @(negedge clk);
        chk(grant_code() == 1, "R5 write request ignored while read owns", grant_code(), 1);
        rd_busy = 1'b0;
        @(negedge clk);
        chk(grant_code() == 0, "R8 idle cycle after release", grant_code(), 0);
        @(negedge clk);
        chk(grant_code() == 2, "R8 pending write granted after idle", grant_code(), 2);
        wr_req = 1'b0;
        @(negedge clk);
        chk(grant_code() == 0, "R8 owner never busy gives one-cycle grant", grant_code(), 0);

        // Pointer still at read after uncontested grants.
        arb(1, 1, 1, "R7 pointer unchanged by lone grants", 0, C_ALT0);

        // Reset mid-stream returns pointer to read.
        arb(1, 1, 2, "R2 alternation continues", 0, C_ALT0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        arb(1, 1, 1, "R1 pointer back to read after reset", 0, C_ALT0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        report();
    end

    initial begin
        #(8 * 20000);
        done = 1'b1;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        report();
    end

endmodule